// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A 32-pin general-purpose I/O bank controlled through a simple 32-bit register bus. Each pin has a direction bit, an output latch bit and a synchronised input sample, and each pin occupies the same bit position in every register. Software changes output bits and interrupt-enable bits by writing masks to dedicated set and clear ports, so no read-modify-write sequence is needed.

Every pin has an event detector with four trigger types: low level, high level, rising edge and falling edge. Any combination of these can be armed on a pin. Detected events latch into a sticky status register, and software clears status bits by writing ones. A single interrupt line is high while any latched status bit also has its enable bit set.

The bus has no handshake. A write takes effect on the clock edge at which `bus_en_i` and `bus_we_i` are both high. Read data is combinational from `bus_addr_i`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit reads 1 (input), so `pin_oe_o` is all zero. The output latch, enable, trigger and status registers are all zero, and `irq_o` is low.
- R2: The direction register at offset 0x134 is read/write. A 1 bit makes the pin an input. `pin_oe_o` is the bitwise inverse of the register, and `pin_o` follows the output latch.
- R3: Writing a mask to offset 0x194 sets those output latch bits. Writing a mask to offset 0x190 clears them. Bits written as 0 are unchanged. The latch reads back at offset 0x13C.
- R4: Writing a mask to offset 0x34 sets interrupt-enable bits, and writing a mask to offset 0x38 clears them. Reading either offset returns the current enable vector.
- R5: Offset 0x138 returns the pin inputs after a two-flop synchroniser, whatever the direction bits hold. A pin change shows up after the second rising clock edge.
- R6: With the rising-detect (0x148) or falling-detect (0x14C) bit set, the matching transition of the synchronised input sets the status bit on the third rising edge after the pin changes.
- R7: With the low-level (0x140) or high-level (0x144) bit set, the status bit is set on every cycle in which the synchronised input holds that level. A clear takes effect once the level has gone.
- R8: A pin with both level bits set signals an event every cycle, so its status bit cannot be cleared.
- R9: The status register at 0x2C is sticky. Writing a 1 clears a bit and writing a 0 leaves it unchanged. Status latches even when the enable bit is clear.
- R10: `irq_o` is high exactly when the bitwise AND of status and enable is non-zero.
- R11: When a status clear and a new event for the same bit fall in the same cycle, the bit stays set.
- R12: Reads from unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 9 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| pin_i | input | 32 | Pad inputs (asynchronous) |
| pin_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad output enables, active high |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench reads back every register through the bus after each write. A bad latch or enable bit therefore shows up at the next read, one cycle after the write, and also on `pin_o`, `pin_oe_o` or `irq_o`. Errors in the synchroniser or in the edge-history register change the cycle in which a status bit appears. Each detection case is therefore sampled exactly two and three edges after the pin change, so an extra or missing stage is reported within three cycles. Clear-versus-event collisions and the both-levels case are checked by reading status right after a clear write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_AW = 9;

  localparam logic [BUS_AW-1:0] OFS_STAT     = 9'h02C;
  localparam logic [BUS_AW-1:0] OFS_EN_SET   = 9'h034;
  localparam logic [BUS_AW-1:0] OFS_EN_CLR   = 9'h038;
  localparam logic [BUS_AW-1:0] OFS_DIR      = 9'h134;
  localparam logic [BUS_AW-1:0] OFS_DIN      = 9'h138;
  localparam logic [BUS_AW-1:0] OFS_DOUT     = 9'h13C;
  localparam logic [BUS_AW-1:0] OFS_LVL_LO   = 9'h140;
  localparam logic [BUS_AW-1:0] OFS_LVL_HI   = 9'h144;
  localparam logic [BUS_AW-1:0] OFS_RISE     = 9'h148;
  localparam logic [BUS_AW-1:0] OFS_FALL     = 9'h14C;
  localparam logic [BUS_AW-1:0] OFS_DOUT_CLR = 9'h190;
  localparam logic [BUS_AW-1:0] OFS_DOUT_SET = 9'h194;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_STAT, SEL_EN_SET, SEL_EN_CLR, SEL_DIR, SEL_DIN, SEL_DOUT,
    SEL_LVL_LO, SEL_LVL_HI, SEL_RISE, SEL_FALL, SEL_DOUT_CLR, SEL_DOUT_SET
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
    case (a)
      OFS_STAT:     decode_addr = SEL_STAT;
      OFS_EN_SET:   decode_addr = SEL_EN_SET;
      OFS_EN_CLR:   decode_addr = SEL_EN_CLR;
      OFS_DIR:      decode_addr = SEL_DIR;
      OFS_DIN:      decode_addr = SEL_DIN;
      OFS_DOUT:     decode_addr = SEL_DOUT;
      OFS_LVL_LO:   decode_addr = SEL_LVL_LO;
      OFS_LVL_HI:   decode_addr = SEL_LVL_HI;
      OFS_RISE:     decode_addr = SEL_RISE;
      OFS_FALL:     decode_addr = SEL_FALL;
      OFS_DOUT_CLR: decode_addr = SEL_DOUT_CLR;
      OFS_DOUT_SET: decode_addr = SEL_DOUT_SET;
      default:      decode_addr = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] lvl_lo_i,
  input  logic [NPINS-1:0] lvl_hi_i,
  input  logic [NPINS-1:0] rise_i,
  input  logic [NPINS-1:0] fall_i,
  input  logic             clr_wr_i,
  input  logic [NPINS-1:0] clr_mask_i,
  output logic [NPINS-1:0] status_o
);
  logic [NPINS-1:0] prev_q, status_q, evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= sync_i;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic hit_lo, hit_hi, hit_re, hit_fe;
    assign hit_lo = lvl_lo_i[p] & ~sync_i[p];
    assign hit_hi = lvl_hi_i[p] &  sync_i[p];
    assign hit_re = rise_i[p]   &  sync_i[p] & ~prev_q[p];
    assign hit_fe = fall_i[p]   & ~sync_i[p] &  prev_q[p];
    assign evt[p] = hit_lo | hit_hi | hit_re | hit_fe;

    // new event beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[p] <= 1'b0;
      else if (evt[p]) status_q[p] <= 1'b1;
      else if (clr_wr_i && clr_mask_i[p]) status_q[p] <= 1'b0;
    end
  end

  assign status_o = status_q;

  // R9
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8
  both_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lvl_lo_i & lvl_hi_i) != '0) |=>
      ((status_q & $past(lvl_lo_i & lvl_hi_i)) == $past(lvl_lo_i & lvl_hi_i)));

  // R11
  clr_collision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && ((evt & clr_mask_i) != '0)) |=>
      ((status_q & $past(evt & clr_mask_i)) == $past(evt & clr_mask_i)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int SYNC_ST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic             wr;
  logic [NPINS-1:0] dir_q, dout_q, en_q, lo_q, hi_q, rise_q, fall_q;
  logic [NPINS-1:0] sync, status;

  assign sel = decode_addr(bus_addr_i);
  assign wr  = bus_en_i & bus_we_i;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      dout_q <= '0;
      en_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DIR:      dir_q  <= bus_wdata_i;
        SEL_DOUT_SET: dout_q <= dout_q | bus_wdata_i;
        SEL_DOUT_CLR: dout_q <= dout_q & ~bus_wdata_i;
        SEL_EN_SET:   en_q   <= en_q | bus_wdata_i;
        SEL_EN_CLR:   en_q   <= en_q & ~bus_wdata_i;
        SEL_LVL_LO:   lo_q   <= bus_wdata_i;
        SEL_LVL_HI:   hi_q   <= bus_wdata_i;
        SEL_RISE:     rise_q <= bus_wdata_i;
        SEL_FALL:     fall_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync),
    .lvl_lo_i  (lo_q),
    .lvl_hi_i  (hi_q),
    .rise_i    (rise_q),
    .fall_i    (fall_q),
    .clr_wr_i  (wr && (sel == SEL_STAT)),
    .clr_mask_i(bus_wdata_i),
    .status_o  (status)
  );

  always_comb begin
    case (sel)
      SEL_STAT:                bus_rdata_o = status;
      SEL_EN_SET, SEL_EN_CLR:  bus_rdata_o = en_q;
      SEL_DIR:                 bus_rdata_o = dir_q;
      SEL_DIN:                 bus_rdata_o = sync;
      SEL_DOUT:                bus_rdata_o = dout_q;
      SEL_LVL_LO:              bus_rdata_o = lo_q;
      SEL_LVL_HI:              bus_rdata_o = hi_q;
      SEL_RISE:                bus_rdata_o = rise_q;
      SEL_FALL:                bus_rdata_o = fall_q;
      default:                 bus_rdata_o = '0;
    endcase
  end

  assign pin_o    = dout_q;
  assign pin_oe_o = ~dir_q;
  assign irq_o    = |(status & en_q);

  // R3
  dout_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_DOUT_SET) |=> ((pin_o & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  // R3
  dout_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_DOUT_CLR) |=> ((pin_o & $past(bus_wdata_i)) == '0));

  // R2
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_DIR) |=> (pin_oe_o == ~$past(bus_wdata_i)));

  // R4
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_EN_SET) |=> ((en_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  // R10
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0));

  // R12
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && !bus_we_i && sel == SEL_NONE) |-> (bus_rdata_o == '0));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic        clk_i = 0, rst_ni = 0;
  logic        bus_en_i = 0, bus_we_i = 0;
  logic [8:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o, pin_i = '0, pin_o, pin_oe_o;
  logic        irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_bank dut (.*);

  typedef struct packed {
    logic        we;
    logic [8:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 9'h134, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 direction reset
    '{1'b0, 9'h13C, 32'h0,        32'h0,        4'd1},
    '{1'b0, 9'h02C, 32'h0,        32'h0,        4'd1},
    '{1'b1, 9'h194, 32'h000000F0, 32'h0,        4'd3},  // R3 set port
    '{1'b0, 9'h13C, 32'h0,        32'h000000F0, 4'd3},
    '{1'b1, 9'h190, 32'h00000030, 32'h0,        4'd3},  // R3 clear port
    '{1'b0, 9'h13C, 32'h0,        32'h000000C0, 4'd3},
    '{1'b1, 9'h134, 32'hFFFF0000, 32'h0,        4'd2},  // R2 direction write
    '{1'b0, 9'h134, 32'h0,        32'hFFFF0000, 4'd2},
    '{1'b1, 9'h034, 32'h00000005, 32'h0,        4'd4},  // R4 enable set/clear
    '{1'b1, 9'h034, 32'h00000008, 32'h0,        4'd4},
    '{1'b0, 9'h038, 32'h0,        32'h0000000D, 4'd4},
    '{1'b1, 9'h038, 32'h00000001, 32'h0,        4'd4},
    '{1'b0, 9'h034, 32'h0,        32'h0000000C, 4'd4},
    '{1'b1, 9'h100, 32'hFFFFFFFF, 32'h0,        4'd12}, // R12 unmapped
    '{1'b0, 9'h100, 32'h0,        32'h0,        4'd12},
    '{1'b0, 9'h13C, 32'h0,        32'h000000C0, 4'd12}
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_en_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    tick();
    bus_en_i = 0; bus_we_i = 0; bus_wdata_i = '0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_en_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_en_i = 0;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  initial begin
    tick(2);
    // R1
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 oe", pin_oe_o, 32'h0);
    check("R1 pin_o", pin_o, 32'h0);
    rst_ni = 1;
    tick();

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].wdata);
      else rd_chk($sformatf("R%0d table %0d", VECS[i].req, i), VECS[i].addr, VECS[i].exp);
    end
    // R2 pad outputs
    check("R2 oe", pin_oe_o, 32'h0000FFFF);
    check("R2 pin_o", pin_o, 32'h000000C0);

    // R5 synchroniser latency, direction ignored
    pin_i = 32'hA5A50003;
    tick();
    rd_chk("R5 one edge", 9'h138, 32'h0);
    tick();
    rd_chk("R5 two edges", 9'h138, 32'hA5A50003);

    // R6 rising on bit4, falling on bit5
    wr(9'h148, 32'h10);
    wr(9'h14C, 32'h20);
    pin_i[4] = 1;
    tick(2);
    rd_chk("R6 rise early", 9'h02C, 32'h0);
    tick();
    rd_chk("R6 rise", 9'h02C, 32'h10);
    wr(9'h02C, 32'h10);
    rd_chk("R9 w1c", 9'h02C, 32'h0);
    pin_i[5] = 1;
    tick(4);
    rd_chk("R6 no fall on rise", 9'h02C, 32'h0);
    pin_i[5] = 0;
    tick(3);
    rd_chk("R6 fall", 9'h02C, 32'h20);
    // R9 latches with enable clear (enable=0xC); R10
    check("R10 masked", {31'b0, irq_o}, 32'h0);
    wr(9'h034, 32'h20);
    check("R10 enabled", {31'b0, irq_o}, 32'h1);
    wr(9'h02C, 32'h00000000);
    rd_chk("R9 zero write", 9'h02C, 32'h20);
    wr(9'h02C, 32'h20);
    check("R10 cleared", {31'b0, irq_o}, 32'h0);
    wr(9'h148, 32'h0);
    wr(9'h14C, 32'h0);

    // R7 high level on bit0 (pin high)
    wr(9'h144, 32'h1);
    tick();
    rd_chk("R7 high level", 9'h02C, 32'h1);
    wr(9'h02C, 32'h1);
    rd_chk("R11 clear vs event", 9'h02C, 32'h1);
    pin_i[0] = 0;
    tick(3);
    wr(9'h02C, 32'h1);
    rd_chk("R7 level gone", 9'h02C, 32'h0);
    wr(9'h144, 32'h0);

    // R8 both levels on bit1
    wr(9'h140, 32'h2);
    wr(9'h144, 32'h2);
    wr(9'h034, 32'h2);
    wr(9'h02C, 32'h2);
    rd_chk("R8 stuck", 9'h02C, 32'h2);
    wr(9'h02C, 32'hFFFFFFFF);
    rd_chk("R8 stuck again", 9'h02C, 32'h2);
    check("R8 irq", {31'b0, irq_o}, 32'h1);
    wr(9'h140, 32'h0);
    wr(9'h144, 32'h0);
    wr(9'h02C, 32'h2);
    rd_chk("R8 released", 9'h02C, 32'h0);
    check("R10 no status", {31'b0, irq_o}, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule